// File: doc/BRIEF.md
# Debug Serial Command Handshake Controller

This block is the chip-side end of a bit-serial debug link. An external host shifts in an 8-bit command, and for writes a 32-bit data word after it. The block decodes the command into a read or a write of one of up to 32 debug registers. It performs that access over a simple register port with strobes and a ready input. It then raises a one-cycle acknowledge. Read results are returned on the serial output, most significant bit first, and the host clocks them out after the acknowledge.

The serial clock and data pins are asynchronous to the core. Both go through the same synchroniser, so bits are taken on the rising edge of the synchronised serial clock. The session exists only while the debug-mode input is high. The rising edge of that input produces the first acknowledge, which opens the session. Only one command can be outstanding at a time. Serial activity while an acknowledge is still owed is thrown away and recorded in a sticky error flag.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: While `dbg_mode` is low, serial clock edges are ignored: no register strobe and no acknowledge are produced.
- R2: A rising edge on `dbg_mode` produces exactly one `ack` pulse, and the first command may follow it.
- R3: A command is 8 bits, sampled MSB first on synchronised rising `ser_clk` edges. Bit 7 set means read and bit 7 clear means write. Bits 4..0 give the register number driven on `reg_sel`.
- R4: For a read, `reg_rd` stays high with a stable `reg_sel` until `reg_ready` is seen. `reg_rdata` is captured in that same cycle.
- R5: For a write, 32 data bits follow the command, MSB first. `reg_wr` stays high with `reg_wdata` until `reg_ready` is seen. `ack` comes in the cycle after the accepted write strobe, and never before the 32nd data bit.
- R6: After a read acknowledge, `ser_dout` presents bit 31 of the captured value. Each later rising `ser_clk` edge moves it to the next lower bit. After 32 edges the block takes commands again.
- R7: Command bits 6 and 5 have no effect on the access performed.
- R8: A rising `ser_clk` edge seen while an access waits for `reg_ready`, or in the acknowledge cycle, is discarded. Such an edge sets `err`, which then stays high until reset.
- R9: Dropping `dbg_mode` aborts any partial command. The next session starts with a fresh bit count.
- R10: `ack` is never high for two cycles in a row, and `reg_rd` and `reg_wr` are never high together.
- R11: After reset, `ack`, `err`, `ser_dout`, `reg_wr` and `reg_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode | input | 1 | High while the core is halted in debug mode |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ack | output | 1 | One-cycle acknowledge pulse |
| err | output | 1 | Sticky protocol error flag |
| reg_sel | output | 5 | Register number of the current access |
| reg_wr | output | 1 | Write strobe, held until ready |
| reg_rd | output | 1 | Read strobe, held until ready |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data |
| reg_ready | input | 1 | Register port completes the access |

## Verification
A bit counter that is off by one shifts every later field. That shows at the ports as a wrong `reg_sel` or a corrupted written word within the same command, and as a rotated value on `ser_dout` within the first read after it. A wrong state after an abort or an error shows as a missing or duplicated `ack` pulse within a few dozen core cycles. The wrong state also leaves data written at a wrong register, which the read-back that follows exposes. A lost sticky error is caught by sampling `err` after later, error-free commands.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_CMD   = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_ACK   = 3'd4,
    ST_SHOUT = 3'd5
  } dbg_state_t;

  // True when the counter value marks the final bit of a field of len bits.
  function automatic logic field_done(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  // Shift one serial bit into the low end of a word.
  function automatic logic [63:0] shift_in(input logic [63:0] word, input logic b);
    return {word[62:0], b};
  endfunction

endpackage

// File: rtl/dbg_sync_edge.sv
module dbg_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dbg_shift_rx.sv
module dbg_shift_rx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {q[W-2:0], bit_in};
  end

endmodule

// File: rtl/dbg_shift_tx.sv
module dbg_shift_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CMD_W       = 8,
  parameter int SEL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ack,
  output logic              err,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ready
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int RW_POS = CMD_W - 1;

  // Synchronised serial pins and edge detect
  logic [1:0] sync_v;
  logic       sclk_s, din_s, sclk_q, ser_rise;

  dbg_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_clk, ser_din}),
    .sync_out (sync_v)
  );

  assign sclk_s   = sync_v[1];
  assign din_s    = sync_v[0];
  assign ser_rise = sclk_s & ~sclk_q;

  // Control state
  dbg_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              is_rd_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;
  logic              dbg_q;

  // Named internal events
  logic              dbg_entry, rx_en, tx_load, tx_shift, pending_hit;
  logic              cnt_last_cmd, cnt_last_data;
  logic [DATA_W-1:0] rx_q, data_next;
  logic [CMD_W-1:0]  cmd_next;

  assign dbg_entry     = dbg_mode & ~dbg_q;
  assign rx_en         = ser_rise && (state == ST_CMD || state == ST_DATA);
  assign pending_hit   = ser_rise && (state == ST_EXEC || state == ST_ACK);
  assign tx_load       = (state == ST_EXEC) && reg_ready && is_rd_q;
  assign tx_shift      = (state == ST_SHOUT) && ser_rise;
  assign cnt_last_cmd  = field_done(32'(bit_cnt), CMD_W);
  assign cnt_last_data = field_done(32'(bit_cnt), DATA_W);
  assign data_next     = DATA_W'(shift_in(64'(rx_q), din_s));
  assign cmd_next      = data_next[CMD_W-1:0];

  dbg_shift_rx #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (rx_en),
    .bit_in (din_s),
    .q      (rx_q)
  );

  logic tx_msb;
  dbg_shift_tx #(.W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_val (reg_rdata),
    .shift    (tx_shift),
    .msb      (tx_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      bit_cnt <= '0;
      is_rd_q <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      dbg_q   <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      dbg_q  <= dbg_mode;
      sclk_q <= sclk_s;
      if (pending_hit) err_q <= 1'b1;
      if (!dbg_mode) begin
        state   <= ST_WAIT;
        bit_cnt <= '0;
      end else begin
        unique case (state)
          ST_WAIT: if (dbg_entry) begin
            is_rd_q <= 1'b0;
            state   <= ST_ACK;
          end
          ST_CMD: if (ser_rise) begin
            if (cnt_last_cmd) begin
              sel_q   <= cmd_next[SEL_W-1:0];
              is_rd_q <= cmd_next[RW_POS];
              bit_cnt <= '0;
              state   <= cmd_next[RW_POS] ? ST_EXEC : ST_DATA;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DATA: if (ser_rise) begin
            if (cnt_last_data) begin
              wdata_q <= data_next;
              bit_cnt <= '0;
              state   <= ST_EXEC;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_EXEC: if (reg_ready) state <= ST_ACK;
          ST_ACK: begin
            bit_cnt <= '0;
            state   <= is_rd_q ? ST_SHOUT : ST_CMD;
          end
          ST_SHOUT: if (ser_rise) begin
            if (cnt_last_data) begin
              bit_cnt <= '0;
              state   <= ST_CMD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

  assign ack       = (state == ST_ACK);
  assign err       = err_q;
  assign reg_sel   = sel_q;
  assign reg_wdata = wdata_q;
  assign reg_rd    = (state == ST_EXEC) && is_rd_q;
  assign reg_wr    = (state == ST_EXEC) && !is_rd_q;
  assign ser_dout  = (state == ST_SHOUT) && tx_msb;

  // Assertions next to the logic they guard
  assert_quiet_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode |=> (!reg_wr && !reg_rd && !ack));

  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && !reg_ready && dbg_mode) |=>
      ((reg_rd || reg_wr) && $stable(reg_sel) && $stable(reg_wdata)));

  assert_ack_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_ready && dbg_mode) |=> ack);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(ser_rise));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_no_tx_shift_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_shift && rx_en));

endmodule

// File: tb/dbg_cmd_ctrl_bench.sv
module dbg_cmd_ctrl_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout, ack, err;
  logic [4:0]  reg_sel;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_ready = 1'b1;

  logic [31:0] mem [32];
  int          ack_cnt = 0;
  int          wr_cnt  = 0;
  int          rd_cnt  = 0;
  int          checks  = 0;
  int          errors  = 0;

  always #2 clk = ~clk;

  dbg_cmd_ctrl u_dbg_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ack(ack), .err(err),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready)
  );

  assign reg_rdata = mem[reg_sel];

  // Register model and port monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (ack) ack_cnt++;
    if (reg_wr && reg_ready) begin
      mem[reg_sel] = reg_wdata;
      wr_cnt++;
    end
    if (reg_rd && reg_ready) rd_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_pulse(input logic b);
    ser_din = b;
    clocks(HALF);
    ser_clk = 1'b1;
    clocks(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) ser_pulse(v[i]);
  endtask

  task automatic do_write(input logic [4:0] sel, input logic [1:0] resv,
                          input logic [31:0] data, input string req);
    int a0, w0;
    a0 = ack_cnt; w0 = wr_cnt;
    send_bits({24'd0, 1'b0, resv, sel}, 8);
    send_bits(data >> 1, 31);
    clocks(10);
    check(ack_cnt == a0, "R5 no ack before last data bit", ack_cnt, a0);
    ser_pulse(data[0]);
    clocks(10);
    check(ack_cnt == a0 + 1 && wr_cnt == w0 + 1, {req, " write strobe then ack"},
          ack_cnt - a0, 1);
    check(mem[sel] == data, {req, " written value"}, mem[sel], data);
  endtask

  task automatic do_read(input logic [4:0] sel, input logic [1:0] resv,
                         input logic [31:0] exp, input string req);
    int a0, r0;
    logic [31:0] got;
    a0 = ack_cnt; r0 = rd_cnt;
    send_bits({24'd0, 1'b1, resv, sel}, 8);
    clocks(10);
    check(ack_cnt == a0 + 1 && rd_cnt == r0 + 1, "R4 read strobe then ack",
          ack_cnt - a0, 1);
    for (int i = 31; i >= 0; i--) begin
      got[i] = ser_dout;
      ser_pulse(1'b0);
    end
    clocks(10);
    check(got == exp, {req, " R6 serial read value"}, got, exp);
  endtask

  // Scenarios
  task automatic t_reset;
    check(!ack && !err && !ser_dout && !reg_wr && !reg_rd, "R11 reset state",
          {27'd0, ack, err, ser_dout, reg_wr, reg_rd}, 0);
  endtask

  task automatic t_before_debug;
    send_bits({24'd0, 8'h03}, 8);
    send_bits(32'hDEAD_BEEF, 32);
    clocks(10);
    check(ack_cnt == 0 && wr_cnt == 0 && rd_cnt == 0, "R1 ignored outside debug",
          ack_cnt + wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_entry;
    dbg_mode = 1'b1;
    clocks(10);
    check(ack_cnt == 1, "R2 single entry ack", ack_cnt, 1);
  endtask

  task automatic t_write_read;
    do_write(5'h0A, 2'b00, 32'h1234_5678, "R3 R5");
    do_read(5'h0A, 2'b00, 32'h1234_5678, "R3");
    do_write(5'h1F, 2'b00, 32'h8000_0001, "R5 edge bits");
    do_read(5'h1F, 2'b00, 32'h8000_0001, "R4");
    do_read(5'h0A, 2'b00, 32'h1234_5678, "R3 other select");
  endtask

  task automatic t_reserved;
    do_write(5'h03, 2'b11, 32'hA5A5_0F0F, "R7 reserved set on write");
    do_read(5'h03, 2'b10, 32'hA5A5_0F0F, "R7 reserved set on read");
    check(mem[5'h0A] == 32'h1234_5678, "R7 no stray register hit", mem[5'h0A],
          32'h1234_5678);
  endtask

  task automatic t_pending_error;
    int a0;
    check(!err, "R8 no error after clean traffic", err, 0);
    reg_ready = 1'b0;
    a0 = ack_cnt;
    send_bits({24'd0, 8'h05}, 8);
    send_bits(32'h0BAD_CAFE, 32);
    clocks(10);
    check(ack_cnt == a0 && reg_wr, "R4 strobe held without ready", ack_cnt - a0, 0);
    ser_pulse(1'b1);
    clocks(10);
    check(err == 1'b1, "R8 edge while pending sets error", err, 1);
    reg_ready = 1'b1;
    clocks(10);
    check(ack_cnt == a0 + 1 && mem[5] == 32'h0BAD_CAFE, "R8 pending access completes",
          mem[5], 32'h0BAD_CAFE);
    do_read(5'h05, 2'b00, 32'h0BAD_CAFE, "R8 stream unaffected");
    check(err == 1'b1, "R8 error stays set", err, 1);
  endtask

  task automatic t_abort;
    int a0;
    send_bits({24'd0, 8'h0A}, 4);
    dbg_mode = 1'b0;
    clocks(10);
    a0 = ack_cnt;
    dbg_mode = 1'b1;
    clocks(10);
    check(ack_cnt == a0 + 1, "R9 re-entry ack", ack_cnt - a0, 1);
    do_write(5'h11, 2'b00, 32'h0F1E_2D3C, "R9 fresh count");
    do_read(5'h11, 2'b00, 32'h0F1E_2D3C, "R9 fresh count");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    clocks(5);
    rst_n = 1'b1;
    clocks(5);
    t_reset();
    t_before_debug();
    t_entry();
    t_write_read();
    t_reserved();
    t_pending_error();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule